// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a DMA engine. Frames arrive as a byte stream with start and end markers. Each frame is stored into memory buffers that software describes through a ring of two-word descriptors. The first word of a descriptor carries a word-aligned buffer address in bits 31:2. Bit 1 of that word marks the last descriptor of the ring, and bit 0 is the ownership flag. The second word is a status word that the engine fills in.

When a frame starts, the engine reads the current descriptor from a simple word-addressed memory port with a one-cycle read latency. It packs the incoming bytes into 32-bit words and writes them into the buffer. It then writes the status word, and after that rewrites the address word with the ownership bit set. A frame longer than one buffer continues in the following descriptors. If a descriptor is still owned when the engine needs it, the engine discards the frame and raises a one-cycle flag. While reception is disabled, the walk position returns to the ring base.

Software sets the ring base word address, the buffer size in 64-byte units and the enable bit. It gives a buffer back to the engine by clearing bit 0 of the address word.

Top module: `rxd_ring_writer`

## Requirements
- R1: With `rx_en` high, a byte with `in_sof` set, seen while idle, makes the engine read the current descriptor's address word. `in_ready` stays low until the descriptor is known. Bits 31:2 of that word give the buffer's word address.
- R2: Frame bytes go into consecutive buffer words in little-endian order: byte k of a descriptor goes to word k/4, bits 8*(k%4)+7 down to 8*(k%4). The unused upper bytes of a final partial word are written as zero.
- R3: The status word (descriptor word 1) holds the byte count in that descriptor in bits 13:0. Bit 14 is set when the descriptor holds the first bytes of a frame, and bit 15 is set when it holds the last bytes. Bits 31:16 are zero.
- R4: The status word is written before the address word. The address word is rewritten with bit 0 set, with bit 1 and bits 31:2 unchanged.
- R5: After a descriptor whose address word has bit 1 set, the next descriptor is read at the ring base. Otherwise the next descriptor is read two words further on.
- R6: A buffer holds `buf_units`*64 bytes. A longer frame continues in the next descriptor. Only the first descriptor carries bit 14 and only the last carries bit 15, and no descriptor beyond the last is claimed.
- R7: If the fetched address word already has bit 0 set, the engine discards the rest of the frame and writes nothing to memory. It pulses `no_buf` for one cycle and keeps its descriptor position.
- R8: While `rx_en` is low and the engine is idle, bytes are accepted and discarded with no memory access. The descriptor position is reloaded from `ring_word`.
- R9: If `rx_en` drops in the middle of a frame, the descriptor being filled is written back with the bytes it holds, with bit 14 as usual and bit 15 clear. The rest of the frame is then discarded and the engine idles.
- R10: While idle and enabled, bytes without `in_sof` are accepted and discarded with no memory access and no change of descriptor position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_word | input | AW | Word address of the first descriptor |
| rx_en | input | 1 | Reception enable |
| buf_units | input | UNIT_W | Buffer size in 64-byte units (nonzero) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (read when low) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| no_buf | output | 1 | One-cycle pulse: descriptor still owned, frame discarded |

## Verification
The assertions rely on four properties of the inputs. The memory returns read data exactly one cycle after a read request. `buf_units` is nonzero and does not change while a frame is in flight. Every frame begins with `in_sof` and ends with `in_eof`. Software rewrites descriptors only while the engine is idle. The stimulus follows these rules: the memory model answers every read on the next edge, the buffer size stays fixed at 128 bytes, each frame is driven as one complete start-to-end sequence, and descriptor updates are made between frames once the engine has gone quiet.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   localparam int DATA_W   = 32;
   localparam int LEN_W    = 14;
   localparam int OWN_BIT  = 0;
   localparam int WRAP_BIT = 1;
   localparam int UNIT_SH  = 6;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_FWAIT,
      S_RECV,
      S_WDATA,
      S_WSTAT,
      S_WADDR,
      S_DROP
   } rxd_state_e;
endpackage

// File: rtl/rxd_byte_packer.sv
module rxd_byte_packer #(
   parameter int LANES = 4,
   parameter int BW    = 8,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                put,
   input  logic [LW-1:0]       lane,
   input  logic [BW-1:0]       din,
   output logic [LANES*BW-1:0] word
);
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("rxd_byte_packer: LANES must be a power of two of at least 2");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          q <= '0;
         else if (clr)                        q <= '0;
         else if (put && lane == LW'(g))      q <= din;
      end
      assign word[g*BW +: BW] = q;
   end

   // a flush and a new byte never share a cycle, so no byte is lost
   assert_no_put_on_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(put && clr));
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
   parameter int AW   = 30,
   parameter int STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic          wrap,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (load)   ptr_q <= base;
      else if (adv)    ptr_q <= wrap ? base : ptr_q + AW'(STEP);
   end

   assign ptr = ptr_q;

   assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap && !load) |=> (ptr_q == $past(base)));

   assert_step_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wrap && !load) |=> (ptr_q == $past(ptr_q) + AW'(STEP)));
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
   import rxd_pkg::*;
#(
   parameter int AW     = 30,
   parameter int UNIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ring_word,
   input  logic              rx_en,
   input  logic [UNIT_W-1:0] buf_units,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              no_buf
);
   localparam int LANES = DATA_W / 8;
   localparam int LW    = $clog2(LANES);
   localparam int BUF_W = DATA_W - 2;

   if (AW < 8 || AW > BUF_W) begin : g_bad_aw
      $error("rxd_ring_writer: AW must lie in 8..30");
   end
   if (UNIT_W + UNIT_SH > LEN_W) begin : g_bad_unit
      $error("rxd_ring_writer: buffer size would not fit the length field");
   end

   rxd_state_e         st_q, st_d;
   logic [BUF_W-1:0]   buf_q;
   logic               wrap_q, first_q, eof_q, stop_q;
   logic [LEN_W-1:0]   len_q, len_nxt, bsize, word_idx;
   logic [AW-1:0]      ptr;
   logic               load, adv, put, clr;
   logic [DATA_W-1:0]  word;

   assign bsize    = LEN_W'({buf_units, {UNIT_SH{1'b0}}});
   assign len_nxt  = len_q + LEN_W'(1);
   assign word_idx = (len_q - LEN_W'(1)) >> LW;

   rxd_ring_ptr #(.AW(AW), .STEP(2)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .base (ring_word),
      .adv  (adv),
      .wrap (wrap_q),
      .ptr  (ptr)
   );

   rxd_byte_packer #(.LANES(LANES), .BW(8)) u_pack (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .put  (put),
      .lane (len_q[LW-1:0]),
      .din  (in_data),
      .word (word)
   );

   always_comb begin
      st_d      = st_q;
      in_ready  = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = ptr;
      mem_wdata = '0;
      no_buf    = 1'b0;
      put       = 1'b0;
      clr       = 1'b0;
      adv       = 1'b0;
      load      = 1'b0;
      case (st_q)
         S_IDLE: begin
            in_ready = !(rx_en && in_sof);
            load     = !rx_en;
            if (rx_en && in_valid && in_sof) st_d = S_FETCH;
         end
         S_FETCH: begin
            mem_req = 1'b1;
            st_d    = S_FWAIT;
         end
         S_FWAIT: begin
            if (!rx_en) begin
               st_d = S_DROP;
            end else if (mem_rdata[OWN_BIT]) begin
               no_buf = 1'b1;
               st_d   = S_DROP;
            end else begin
               st_d = S_RECV;
            end
         end
         S_RECV: begin
            in_ready = rx_en;
            if (!rx_en) begin
               if (len_q == '0)                st_d = S_DROP;
               else if (len_q[LW-1:0] != '0)   st_d = S_WDATA;
               else                            st_d = S_WSTAT;
            end else if (in_valid) begin
               put = 1'b1;
               if (in_eof || len_q[LW-1:0] == LW'(LANES - 1) || len_nxt == bsize)
                  st_d = S_WDATA;
            end
         end
         S_WDATA: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = buf_q[AW-1:0] + AW'(word_idx);
            mem_wdata = word;
            clr       = 1'b1;
            st_d      = (eof_q || stop_q || len_q == bsize) ? S_WSTAT : S_RECV;
         end
         S_WSTAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr + AW'(1);
            mem_wdata = {16'b0, eof_q, first_q, len_q};
            st_d      = S_WADDR;
         end
         S_WADDR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr;
            mem_wdata = {buf_q, wrap_q, 1'b1};
            adv       = 1'b1;
            if (stop_q)      st_d = S_DROP;
            else if (eof_q)  st_d = S_IDLE;
            else             st_d = S_FETCH;
         end
         S_DROP: begin
            in_ready = 1'b1;
            if (in_valid && in_eof) st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         buf_q   <= '0;
         wrap_q  <= 1'b0;
         first_q <= 1'b0;
         eof_q   <= 1'b0;
         stop_q  <= 1'b0;
         len_q   <= '0;
      end else begin
         st_q <= st_d;
         case (st_q)
            S_IDLE: begin
               if (rx_en && in_valid && in_sof) first_q <= 1'b1;
            end
            S_FWAIT: begin
               if (rx_en && !mem_rdata[OWN_BIT]) begin
                  buf_q  <= mem_rdata[DATA_W-1:2];
                  wrap_q <= mem_rdata[WRAP_BIT];
                  len_q  <= '0;
                  eof_q  <= 1'b0;
                  stop_q <= 1'b0;
               end
            end
            S_RECV: begin
               if (!rx_en) begin
                  if (len_q != '0) stop_q <= 1'b1;
               end else if (in_valid) begin
                  len_q <= len_nxt;
                  if (in_eof) eof_q <= 1'b1;
               end
            end
            S_WADDR: first_q <= 1'b0;
            default: ;
         endcase
      end
   end

   // ownership is handed over only right after the length is in memory
   assert_stat_before_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WADDR) |-> ($past(st_q) == S_WSTAT));

   assert_fetch_stalls_stream_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_FETCH || st_q == S_FWAIT) |-> !in_ready);

   assert_write_inside_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WDATA) |-> (len_q != '0 && len_q <= bsize));

   assert_owned_means_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      no_buf |=> (st_q == S_DROP && $stable(ptr)));

   assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && !rx_en) |-> (!mem_req && in_ready));

   assert_stop_closes_desc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_RECV && !rx_en && len_q != '0) |=> (st_q == S_WDATA || st_q == S_WSTAT));
endmodule

// File: tb/rxd_ring_writer_bench.sv
`timescale 1ns/1ps
module rxd_ring_writer_bench;
   localparam int AW        = 30;
   localparam int NDESC     = 4;
   localparam int RING_W    = 64;
   localparam int BUF_BYTES = 128;

   // frame length, descriptors it must occupy
   localparam int NVEC = 7;
   localparam int VEC [NVEC][2] = '{
      '{5, 1}, '{12, 1}, '{1, 1}, '{128, 1}, '{200, 2}, '{3, 1}, '{131, 2}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ring_word = AW'(RING_W);
   logic          rx_en = 1'b0;
   logic [7:0]    buf_units = 8'd2;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = 8'h00;
   logic          in_sof = 1'b0;
   logic          in_eof = 1'b0;
   logic          in_ready;
   logic          mem_req, mem_we, no_buf;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = 32'h0;

   logic [31:0]   mem [0:1023];
   logic          sw_we = 1'b0;
   int            sw_addr = 0;
   logic [31:0]   sw_data = 32'h0;

   int n_chk = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   int nb_cnt = 0;
   int order_bad = 0;
   int last_wr = -1;
   int cur = 0;
   bit timed_out = 1'b0;

   always #2.5 clk = ~clk;

   rxd_ring_writer #(.AW(AW), .UNIT_W(8)) u_rxd_ring_writer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ring_word(ring_word),
      .rx_en    (rx_en),
      .buf_units(buf_units),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .in_ready (in_ready),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .no_buf   (no_buf)
   );

   always @(posedge clk) begin
      if (sw_we) mem[sw_addr] <= sw_data;
      else if (mem_req) begin
         if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:0]];
      end
   end

   always @(negedge clk) begin
      if (no_buf) nb_cnt++;
      if (mem_req && mem_we) begin
         wr_cnt++;
         if (mem_wdata[0] && mem_addr[9:0] >= 10'(RING_W) &&
             mem_addr[9:0] < 10'(RING_W + 2*NDESC) && !mem_addr[0]) begin
            if (last_wr != int'(mem_addr[9:0]) + 1) order_bad++;
         end
         last_wr = int'(mem_addr[9:0]);
      end
   end

   function automatic int desc_w(int d);  return RING_W + 2*d;         endfunction
   function automatic int buf_w(int d);   return 256 + 128*d;          endfunction
   function automatic logic [31:0] addr_word(int d);
      return 32'(buf_w(d) * 4) | ((d == NDESC-1) ? 32'h2 : 32'h0);
   endfunction
   function automatic logic [7:0] byte_of(int fid, int i);
      return 8'(fid*37 + i*11 + 5);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic sw_write(int a, logic [31:0] d);
      @(negedge clk);
      sw_we = 1'b1; sw_addr = a; sw_data = d;
      @(negedge clk);
      sw_we = 1'b0;
   endtask

   task automatic send_frame(int fid, int len, bit with_sof, int stop_at);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (stop_at > 0 && i == stop_at) rx_en = 1'b0;
         in_valid = 1'b1;
         in_data  = byte_of(fid, i);
         in_sof   = with_sof && (i == 0);
         in_eof   = (i == len - 1);
         forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
         end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   task automatic verify(int fid, int len, int start, int ndesc, bit last_eof, string req);
      int seg0 = 0;
      for (int j = 0; j < ndesc; j++) begin
         int d = (start + j) % NDESC;
         int seg = (len - seg0 < BUF_BYTES) ? len - seg0 : BUF_BYTES;
         logic [31:0] st = 32'(seg);
         if (j == 0) st |= 32'h4000;
         if (j == ndesc - 1 && last_eof) st |= 32'h8000;
         chk(req, "status word (R3)", mem[desc_w(d)+1], st);
         chk(req, "address word owned (R4)", mem[desc_w(d)], addr_word(d) | 32'h1);
         for (int w = 0; w < (seg + 3) / 4; w++) begin
            logic [31:0] e = 32'h0;
            for (int b = 0; b < 4; b++)
               if (w*4 + b < seg) e |= 32'(byte_of(fid, seg0 + w*4 + b)) << (8*b);
            chk(req, "buffer word (R2)", mem[buf_w(d)+w], e);
         end
         seg0 += seg;
      end
      chk(req, "next descriptor unclaimed (R6)",
          32'(mem[desc_w((start + ndesc) % NDESC)][0]), 32'h0);
   endtask

   task automatic give_back(int start, int ndesc);
      for (int j = 0; j < ndesc; j++) begin
         int d = (start + j) % NDESC;
         sw_write(desc_w(d), addr_word(d));
         sw_write(desc_w(d) + 1, 32'h0);
      end
   endtask

   task automatic run_all();
      int w0, n0;
      for (int d = 0; d < NDESC; d++) begin
         sw_write(desc_w(d), addr_word(d));
         sw_write(desc_w(d) + 1, 32'h0);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "reset: no memory request", 32'(mem_req), 32'h0);
      chk("R7", "reset: no_buf low", 32'(no_buf), 32'h0);
      chk("R8", "reset: stream accepted while disabled", 32'(in_ready), 32'h1);

      rx_en = 1'b1;
      repeat (2) @(negedge clk);
      // table of frames; R5 wrap is crossed as the ring is reused
      for (int v = 0; v < NVEC; v++) begin
         send_frame(v + 1, VEC[v][0], 1'b1, 0);
         verify(v + 1, VEC[v][0], cur, VEC[v][1], 1'b1, "R1/R5/R6");
         give_back(cur, VEC[v][1]);
         cur = (cur + VEC[v][1]) % NDESC;
      end

      // R7: descriptor still owned
      sw_write(desc_w(cur), addr_word(cur) | 32'h1);
      w0 = wr_cnt; n0 = nb_cnt;
      send_frame(20, 10, 1'b1, 0);
      chk("R7", "no_buf pulses", 32'(nb_cnt - n0), 32'h1);
      chk("R7", "memory writes", 32'(wr_cnt - w0), 32'h0);
      sw_write(desc_w(cur), addr_word(cur));
      send_frame(21, 9, 1'b1, 0);
      verify(21, 9, cur, 1, 1'b1, "R7");
      give_back(cur, 1);
      cur = (cur + 1) % NDESC;

      // R10: bytes without a start marker while idle
      w0 = wr_cnt;
      send_frame(22, 6, 1'b0, 0);
      chk("R10", "memory writes", 32'(wr_cnt - w0), 32'h0);
      send_frame(23, 5, 1'b1, 0);
      verify(23, 5, cur, 1, 1'b1, "R10");
      give_back(cur, 1);
      cur = (cur + 1) % NDESC;

      // R8: disabled, then restart at a new ring base
      rx_en = 1'b0;
      w0 = wr_cnt;
      send_frame(24, 8, 1'b1, 0);
      chk("R8", "memory writes while disabled", 32'(wr_cnt - w0), 32'h0);
      ring_word = AW'(desc_w(1));
      repeat (3) @(negedge clk);
      rx_en = 1'b1;
      send_frame(25, 7, 1'b1, 0);
      verify(25, 7, 1, 1, 1'b1, "R8");
      give_back(1, 1);
      rx_en = 1'b0;
      ring_word = AW'(RING_W);
      repeat (3) @(negedge clk);
      rx_en = 1'b1;
      cur = 0;

      // R9: enable dropped after six bytes of a twenty-byte frame
      w0 = wr_cnt;
      send_frame(26, 20, 1'b1, 6);
      chk("R9", "writes: two data, status, address", 32'(wr_cnt - w0), 32'h4);
      verify(26, 6, 0, 1, 1'b0, "R9");
      chk("R9", "idle and accepting while disabled", 32'(in_ready), 32'h1);
      give_back(0, 1);
      rx_en = 1'b1;
      repeat (2) @(negedge clk);
      send_frame(27, 4, 1'b1, 0);
      verify(27, 4, 0, 1, 1'b1, "R9");

      chk("R4", "status written before ownership", 32'(order_bad), 32'h0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
      end
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule